// File: doc/BRIEF.md
# Byte Handshake Shift-Port Interface

This block is a byte-wide, memory-mapped peripheral laid out like a general-purpose interface adapter's register file. A host CPU uses it to swap command bytes and reply bytes with a bus-side command processor. The host does not clock a serial shift register. Each byte is moved by the host toggling two handshake bits in the port register: an active-low transfer-in-progress bit and an acknowledge level. The block answers by setting interrupt flags and by driving an active-low "data ready" bit in the same port register.

In the output direction, each handshake step copies the shift register into a command buffer. When the transfer closes, the command processor sees a one-cycle completion strobe and can read the captured bytes through an index port. Once it has placed its reply, the processor pulses a "processed" input. In the input direction, each step loads the next reply byte, taken from the processor through an index/data pair, into the shift register. An interrupt output follows the summary flag bit, gated by a single enable bit.

Top module: `byte_handshake_port`

## Requirements
- R1: The register index is cpu_addr[12:9]. Index 0 is the handshake port, 10 the shift register, 11 the aux control, 13 the flag register and 14 the enable register. Every other index (e.g. 4, 15) is a plain byte that reads back the last value written. The aux, shift and enable registers also read back the value written.
- R2: After reset the port register reads 0x28 (bit 3 ready_n and bit 5 tip_n high). All other registers read 0x00. irq is low, cmd_len is 0 and xfer_count is 0.
- R3: A write to the flag register clears each of bits 6:0 whose data bit is 1. It also clears bit 7, and bit 7 is then recomputed as the OR of the remaining bits 6:0.
- R4: Bit 7 of the last write to the enable register is the interrupt enable. irq is high exactly while flag bit 7 and that enable bit are both 1.
- R5: A port write whose bit 5 is 0 while no transfer is open starts a transfer. It resets the command and reply offsets to zero and moves the first byte in that same write.
- R6: With aux bit 4 = 1 (output), each byte step stores the shift register at the next command buffer position. It also sets flag bits 2 and 7 and sets port bit 3.
- R7: With aux bit 4 = 0 (input), each byte step loads reply byte rsp_idx into the shift register and sets flag bits 2 and 7. Port bit 3 is set only when the step delivers the last byte (rsp_len-th).
- R8: Any read or write of the shift register clears flag bit 2 and leaves flag bit 7 unchanged.
- R9: A port write with bit 5 = 1 while a transfer is open ends the transfer and increments xfer_count. cmd_done pulses for one cycle only if at least one command byte was captured. The captured bytes stay readable.
- R10: A proc_done pulse clears port bit 3, sets flag bits 2 and 7 and clears the shift register to 0x00. This wins over a host flag clear or shift write in the same cycle.
- R11: The command buffer holds CMD_DEPTH (100) bytes. Further output steps are dropped and set the sticky err_overflow.
- R12: An input step past rsp_len loads 0x00, sets the sticky err_underrun and sets port bit 3.
- R13: A port write that changes neither bit 5 nor bit 4 moves no byte: cmd_len and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 13 | Byte address, register index in bits 12:9 |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |
| cmd_rd_idx | input | 7 | Command buffer read index |
| cmd_rd_byte | output | 8 | Command byte at cmd_rd_idx |
| cmd_len | output | 7 | Number of captured command bytes |
| cmd_done | output | 1 | One-cycle command-complete strobe |
| rsp_len | input | 7 | Reply length in bytes |
| rsp_idx | output | 7 | Index of the reply byte requested |
| rsp_byte | input | 8 | Reply byte at rsp_idx |
| proc_done | input | 1 | Command processed pulse |
| xfer_count | output | 16 | Count of ended transfers |
| err_overflow | output | 1 | Sticky command buffer overflow |
| err_underrun | output | 1 | Sticky reply underrun |

## Verification
The processor's proc_done pulse can arrive in the same cycle as a host access that changes the same state. Two such cases are tested: a write-one-to-clear of the flag register, and a write of the shift register. The bench provokes each by raising proc_done during the host's write cycle. It then reads the flag register back and expects 0x84, and reads the shift register back and expects 0x00. This shows that the set side of the processor's result takes priority over the host's clear or load.

// File: rtl/shif_pkg.sv
package shif_pkg;
   localparam int         REG_NUM   = 16;
   localparam logic [3:0] IX_PORT   = 4'd0;
   localparam logic [3:0] IX_SHIFT  = 4'd10;
   localparam logic [3:0] IX_AUX    = 4'd11;
   localparam logic [3:0] IX_FLAG   = 4'd13;
   localparam logic [3:0] IX_ENA    = 4'd14;
   localparam int         PB_READYN = 3;
   localparam int         PB_ACK    = 4;
   localparam int         PB_TIPN   = 5;
   localparam int         AUX_DIR   = 4;
   localparam int         FLG_SHIFT = 2;
   localparam int         FLG_ANY   = 7;
   localparam int         ENA_BIT   = 7;
   localparam logic [7:0] PORT_RST  = 8'h28;
endpackage

// File: rtl/shif_flags.sv
module shif_flags
   import shif_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_flag,
   input  logic       wr_ena,
   input  logic [7:0] wdata,
   input  logic       shift_touch,
   input  logic       raise,
   output logic [7:0] flag_q,
   output logic [7:0] ena_q,
   output logic       irq
);
   logic [6:0] lo_q, lo_n;
   logic       any_q, any_n;

   always_comb begin
      lo_n  = lo_q;
      any_n = any_q;
      if (wr_flag) begin
         lo_n  = lo_q & ~wdata[6:0];
         any_n = |lo_n;
      end
      if (shift_touch) lo_n[FLG_SHIFT] = 1'b0;
      if (raise) begin
         lo_n[FLG_SHIFT] = 1'b1;
         any_n           = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         any_q <= 1'b0;
         ena_q <= 8'h00;
      end else begin
         lo_q  <= lo_n;
         any_q <= any_n;
         if (wr_ena) ena_q <= wdata;
      end
   end

   assign flag_q = {any_q, lo_q};
   assign irq    = any_q & ena_q[ENA_BIT];

   AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      raise |=> (flag_q[FLG_ANY] && flag_q[FLG_SHIFT])); // R6
   AST_FLAG_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && wdata == 8'hFF && !raise) |=> (flag_q == 8'h00)); // R3
   AST_TOUCH_KEEPS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_touch && !raise && !wr_flag) |=> (!flag_q[FLG_SHIFT] && flag_q[FLG_ANY] == $past(flag_q[FLG_ANY]))); // R8
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ena && !wdata[ENA_BIT]) |=> !irq); // R4
endmodule

// File: rtl/shif_cmdbuf.sv
module shif_cmdbuf #(
   parameter int DEPTH = 100,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [7:0]    din,
   input  logic [CW-1:0] rd_idx,
   output logic [7:0]    rd_byte,
   output logic [CW-1:0] cnt_q,
   output logic          ovf_q
);
   localparam int          AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("shif_cmdbuf: DEPTH must be at least 2");
   end

   logic [7:0]    mem [DEPTH];
   logic [CW-1:0] base;

   assign base = clr ? '0 : cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (push) begin
         if (base < FULL) begin
            mem[base[AW-1:0]] <= din;
            cnt_q             <= base + 1'b1;
         end else begin
            cnt_q <= base;
            ovf_q <= 1'b1;
         end
      end else if (clr) begin
         cnt_q <= '0;
      end
   end

   assign rd_byte = (rd_idx < FULL) ? mem[rd_idx[AW-1:0]] : 8'h00;

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL); // R11
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q); // R11
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr && cnt_q == FULL) |=> (cnt_q == FULL && ovf_q)); // R11
endmodule

// File: rtl/shif_seq.sv
module shif_seq #(
   parameter int RW = 7,
   parameter int XW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          port_wr,
   input  logic          new_tip,
   input  logic          new_ack,
   input  logic          dir_out,
   input  logic          cmd_nonempty,
   input  logic [RW-1:0] rsp_len,
   output logic          start,
   output logic          out_step,
   output logic          in_step,
   output logic          in_ok,
   output logic          in_last,
   output logic [RW-1:0] rsp_idx,
   output logic          cmd_done,
   output logic [XW-1:0] xfer_cnt,
   output logic          underrun
);
   logic          tip_q, ack_q, tip_chg, finish, step;
   logic [RW-1:0] in_q, cur_in;

   assign tip_chg  = port_wr && (new_tip != tip_q);
   assign start    = tip_chg && new_tip;
   assign finish   = tip_chg && !new_tip;
   assign step     = start || (port_wr && !tip_chg && (new_ack != ack_q));
   assign out_step = step && dir_out;
   assign in_step  = step && !dir_out;
   assign cur_in   = start ? '0 : in_q;
   assign rsp_idx  = cur_in;
   assign in_ok    = cur_in < rsp_len;
   assign in_last  = !in_ok || (RW'(cur_in + 1'b1) == rsp_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tip_q    <= 1'b0;
         ack_q    <= 1'b0;
         in_q     <= '0;
         cmd_done <= 1'b0;
         xfer_cnt <= '0;
         underrun <= 1'b0;
      end else begin
         if (port_wr) begin
            tip_q <= new_tip;
            ack_q <= new_ack;
         end
         cmd_done <= finish && cmd_nonempty;
         if (finish) xfer_cnt <= xfer_cnt + 1'b1;
         if (in_step) begin
            in_q <= in_ok ? RW'(cur_in + 1'b1) : cur_in;
            if (!in_ok) underrun <= 1'b1;
         end else if (start) begin
            in_q <= '0;
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> !cmd_done); // R9
   AST_XFER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      finish |=> (xfer_cnt == $past(xfer_cnt) + 1'b1)); // R9
   AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      underrun |=> underrun); // R12
endmodule

// File: rtl/byte_handshake_port.sv
module byte_handshake_port
   import shif_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int IDX_LSB    = 9,
   parameter int CMD_DEPTH  = 100,
   parameter int RSP_DEPTH  = 100,
   parameter int XFER_W     = 16,
   parameter bit KEEP_SPARE = 1'b1,
   localparam int CMD_CW    = $clog2(CMD_DEPTH + 1),
   localparam int RSP_CW    = $clog2(RSP_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic [7:0]        cpu_rdata,
   output logic              irq,
   input  logic [CMD_CW-1:0] cmd_rd_idx,
   output logic [7:0]        cmd_rd_byte,
   output logic [CMD_CW-1:0] cmd_len,
   output logic              cmd_done,
   input  logic [RSP_CW-1:0] rsp_len,
   output logic [RSP_CW-1:0] rsp_idx,
   input  logic [7:0]        rsp_byte,
   input  logic              proc_done,
   output logic [XFER_W-1:0] xfer_count,
   output logic              err_overflow,
   output logic              err_underrun
);
   if (ADDR_W != IDX_LSB + 4) begin : g_bad_addr
      $error("byte_handshake_port: ADDR_W must equal IDX_LSB + 4");
   end

   logic [3:0] idx;
   logic       wr, port_wr, shift_wr, aux_wr, spare_hit;
   logic [7:0] port_q, port_n, sr_q, sr_n, aux_q, flag_q, ena_q, spare_rd;
   logic       start, out_step, in_step, in_ok, in_last;
   logic       unused_low;

   assign idx        = cpu_addr[ADDR_W-1:IDX_LSB];
   assign unused_low = ^cpu_addr[IDX_LSB-1:0];
   assign wr         = cpu_sel && cpu_we;
   assign port_wr    = wr && idx == IX_PORT;
   assign shift_wr   = wr && idx == IX_SHIFT;
   assign aux_wr     = wr && idx == IX_AUX;
   assign spare_hit  = !(idx inside {IX_PORT, IX_SHIFT, IX_AUX, IX_FLAG, IX_ENA});

   shif_seq #(.RW(RSP_CW), .XW(XFER_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .port_wr(port_wr),
      .new_tip(!cpu_wdata[PB_TIPN]), .new_ack(cpu_wdata[PB_ACK]),
      .dir_out(aux_q[AUX_DIR]), .cmd_nonempty(cmd_len != '0), .rsp_len(rsp_len),
      .start(start), .out_step(out_step), .in_step(in_step), .in_ok(in_ok),
      .in_last(in_last), .rsp_idx(rsp_idx), .cmd_done(cmd_done),
      .xfer_cnt(xfer_count), .underrun(err_underrun));

   shif_cmdbuf #(.DEPTH(CMD_DEPTH), .CW(CMD_CW)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(start), .push(out_step), .din(sr_q),
      .rd_idx(cmd_rd_idx), .rd_byte(cmd_rd_byte), .cnt_q(cmd_len),
      .ovf_q(err_overflow));

   shif_flags u_flags (
      .clk(clk), .rst_n(rst_n), .wr_flag(wr && idx == IX_FLAG),
      .wr_ena(wr && idx == IX_ENA), .wdata(cpu_wdata),
      .shift_touch(cpu_sel && idx == IX_SHIFT),
      .raise(out_step || in_step || proc_done),
      .flag_q(flag_q), .ena_q(ena_q), .irq(irq));

   always_comb begin
      port_n = port_wr ? cpu_wdata : port_q;
      if (out_step || (in_step && in_last)) port_n[PB_READYN] = 1'b1;
      if (proc_done) port_n[PB_READYN] = 1'b0;
      sr_n = shift_wr ? cpu_wdata : sr_q;
      if (in_step) sr_n = in_ok ? rsp_byte : 8'h00;
      if (proc_done) sr_n = 8'h00;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         port_q <= PORT_RST;
         sr_q   <= 8'h00;
         aux_q  <= 8'h00;
      end else begin
         port_q <= port_n;
         sr_q   <= sr_n;
         if (aux_wr) aux_q <= cpu_wdata;
      end
   end

   if (KEEP_SPARE) begin : g_keep
      logic [7:0] spare_q [REG_NUM];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < REG_NUM; i++) spare_q[i] <= 8'h00;
         end else if (wr && spare_hit) begin
            spare_q[idx] <= cpu_wdata;
         end
      end
      assign spare_rd = spare_q[idx];
   end else begin : g_zero
      logic unused_spare;
      assign unused_spare = spare_hit;
      assign spare_rd     = 8'h00;
   end

   always_comb begin
      case (idx)
         IX_PORT:  cpu_rdata = port_q;
         IX_SHIFT: cpu_rdata = sr_q;
         IX_AUX:   cpu_rdata = aux_q;
         IX_FLAG:  cpu_rdata = flag_q;
         IX_ENA:   cpu_rdata = ena_q;
         default:  cpu_rdata = spare_rd;
      endcase
   end

   AST_PROC_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      proc_done |=> (!port_q[PB_READYN] && sr_q == 8'h00 && flag_q[FLG_ANY] && flag_q[FLG_SHIFT])); // R10
   AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_step && in_last && !proc_done) |=> port_q[PB_READYN]); // R7
   AST_OUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_step && !proc_done) |=> port_q[PB_READYN]); // R6
endmodule

// File: tb/sim_byte_handshake_port.sv
module sim_byte_handshake_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_sel = 1'b0, cpu_we = 1'b0, proc_done = 1'b0;
   logic [12:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0, cpu_rdata, cmd_rd_byte, rsp_byte;
   logic        irq, cmd_done, err_overflow, err_underrun;
   logic [6:0]  cmd_rd_idx = '0, cmd_len, rsp_len = '0, rsp_idx;
   logic [15:0] xfer_count;
   logic        done_seen = 1'b0;
   logic [7:0]  v;
   int          tests = 0, fails = 0;

   always #2 clk = ~clk;

   byte_handshake_port u0 (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .irq(irq), .cmd_rd_idx(cmd_rd_idx), .cmd_rd_byte(cmd_rd_byte),
      .cmd_len(cmd_len), .cmd_done(cmd_done), .rsp_len(rsp_len),
      .rsp_idx(rsp_idx), .rsp_byte(rsp_byte), .proc_done(proc_done),
      .xfer_count(xfer_count), .err_overflow(err_overflow),
      .err_underrun(err_underrun));

   always_comb begin
      case (rsp_idx)
         7'd0:    rsp_byte = 8'h11;
         7'd1:    rsp_byte = 8'h22;
         7'd2:    rsp_byte = 8'h33;
         default: rsp_byte = 8'hEE;
      endcase
   end

   // {write index, write data, read index, expected}
   localparam logic [23:0] VEC [7] = '{
      {4'd11, 8'h10, 4'd11, 8'h10},
      {4'd4,  8'h5A, 4'd4,  8'h5A},
      {4'd15, 8'hC3, 4'd15, 8'hC3},
      {4'd14, 8'h84, 4'd14, 8'h84},
      {4'd10, 8'h3C, 4'd10, 8'h3C},
      {4'd14, 8'h04, 4'd14, 8'h04},
      {4'd11, 8'h00, 4'd11, 8'h00}};

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [3:0] ix, input logic [7:0] d, input logic pd);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = {ix, 9'h000}; cpu_wdata = d; proc_done = pd;
      @(negedge clk);
      cpu_sel = 1'b0; cpu_we = 1'b0; proc_done = 1'b0;
      done_seen = cmd_done;
   endtask

   task automatic rd(input logic [3:0] ix, output logic [7:0] d);
      @(negedge clk);
      cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = {ix, 9'h000};
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_sel = 1'b0;
   endtask

   task automatic pulse_done();
      @(negedge clk); proc_done = 1'b1;
      @(negedge clk); proc_done = 1'b0;
   endtask

   task automatic cmd_at(input int i, output logic [7:0] d);
      cmd_rd_idx = 7'(i);
      #1 d = cmd_rd_byte;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R2 reset state
      rd(4'd0, v);  chk("R2 port reset", v, 8'h28);
      rd(4'd10, v); chk("R2 shift reset", v, 8'h00);
      rd(4'd11, v); chk("R2 aux reset", v, 8'h00);
      rd(4'd13, v); chk("R2 flag reset", v, 8'h00);
      rd(4'd14, v); chk("R2 enable reset", v, 8'h00);
      chk("R2 irq/len/count", {irq, cmd_len, xfer_count}, 32'h0);

      // R1 register file vectors
      for (int i = 0; i < 7; i++) begin
         wr(VEC[i][23:20], VEC[i][19:12], 1'b0);
         rd(VEC[i][11:8], v);
         chk($sformatf("R1 vector %0d", i), v, VEC[i][7:0]);
      end

      // output transfer
      wr(4'd11, 8'h10, 1'b0);
      wr(4'd10, 8'hA1, 1'b0);
      wr(4'd0, 8'h00, 1'b0);
      chk("R5 start moves first byte", cmd_len, 7'd1);
      cmd_at(0, v); chk("R6 byte0", v, 8'hA1);
      rd(4'd13, v); chk("R6 flags after step", v, 8'h84);
      rd(4'd0, v);  chk("R6 ready_n high", v, 8'h08);
      wr(4'd10, 8'hB2, 1'b0);
      rd(4'd13, v); chk("R8 shift write clears bit2 only", v, 8'h80);
      wr(4'd0, 8'h10, 1'b0);
      wr(4'd10, 8'hC3, 1'b0);
      wr(4'd0, 8'h00, 1'b0);
      chk("R6 three bytes", cmd_len, 7'd3);
      cmd_at(1, v); chk("R6 byte1", v, 8'hB2);
      wr(4'd13, 8'hFF, 1'b0);
      rd(4'd13, v); chk("R3 clear all", v, 8'h00);
      wr(4'd0, 8'h00, 1'b0);
      chk("R13 no byte moved", cmd_len, 7'd3);
      rd(4'd13, v); chk("R13 flags untouched", v, 8'h00);
      wr(4'd0, 8'h20, 1'b0);
      chk("R9 done strobe", done_seen, 1'b1);
      chk("R9 transfer count", xfer_count, 16'd1);
      cmd_at(2, v); chk("R9 bytes kept", v, 8'hC3);

      // processed result and interrupt
      wr(4'd14, 8'h84, 1'b0);
      pulse_done();
      chk("R4 irq on", irq, 1'b1);
      rd(4'd13, v); chk("R10 flags", v, 8'h84);
      rd(4'd0, v);  chk("R10 ready_n low", v, 8'h20);
      rd(4'd10, v); chk("R10 shift cleared", v, 8'h00);
      rd(4'd13, v); chk("R8 shift read clears bit2", v, 8'h80);
      chk("R4 irq still on", irq, 1'b1);
      wr(4'd13, 8'h00, 1'b0);
      rd(4'd13, v); chk("R3 bit7 recomputed", v, 8'h00);
      chk("R4 irq off", irq, 1'b0);
      pulse_done();
      wr(4'd14, 8'h04, 1'b0);
      chk("R4 disabled irq", irq, 1'b0);
      wr(4'd13, 8'h04, 1'b0);

      // input transfer
      rsp_len = 7'd3;
      wr(4'd11, 8'h00, 1'b0);
      wr(4'd0, 8'h00, 1'b0);
      rd(4'd10, v); chk("R7 reply byte0", v, 8'h11);
      rd(4'd0, v);  chk("R7 not last", v, 8'h00);
      wr(4'd0, 8'h10, 1'b0);
      rd(4'd10, v); chk("R7 reply byte1", v, 8'h22);
      wr(4'd0, 8'h00, 1'b0);
      rd(4'd10, v); chk("R7 reply byte2", v, 8'h33);
      rd(4'd0, v);  chk("R7 last releases", v, 8'h08);
      chk("R12 no underrun yet", err_underrun, 1'b0);
      wr(4'd0, 8'h10, 1'b0);
      rd(4'd10, v); chk("R12 past end reads zero", v, 8'h00);
      chk("R12 underrun sticky", err_underrun, 1'b1);
      rd(4'd0, v);  chk("R12 ready_n high", v, 8'h18);
      wr(4'd0, 8'h30, 1'b0);
      chk("R9 no strobe when empty", done_seen, 1'b0);
      chk("R9 count on every end", xfer_count, 16'd2);

      // same-cycle collisions
      wr(4'd13, 8'hFF, 1'b0);
      wr(4'd13, 8'hFF, 1'b1);
      rd(4'd13, v); chk("R10 wins over flag clear", v, 8'h84);
      wr(4'd10, 8'h55, 1'b1);
      rd(4'd10, v); chk("R10 wins over shift write", v, 8'h00);

      // overflow
      wr(4'd11, 8'h10, 1'b0);
      wr(4'd10, 8'h77, 1'b0);
      wr(4'd0, 8'h00, 1'b0);
      for (int i = 0; i < 99; i++) wr(4'd0, (i % 2 == 0) ? 8'h10 : 8'h00, 1'b0);
      chk("R11 full no error", {cmd_len, err_overflow}, {7'd100, 1'b0});
      wr(4'd0, 8'h00, 1'b0);
      chk("R11 dropped and sticky", {cmd_len, err_overflow}, {7'd100, 1'b1});
      cmd_at(99, v); chk("R11 last stored byte", v, 8'h77);
      wr(4'd0, 8'h20, 1'b0);
      chk("R9 strobe after overflow", {done_seen, xfer_count}, {1'b1, 16'd3});

      finish_run();
   end
endmodule